// File: doc/BRIEF.md
# Software-Interrupt Register Write Permission Checker

This block decides what happens when software attempts a write to the group-0 software-generated-interrupt request register. It looks at the exception level the write comes from, the execution state of the higher levels, the hypervisor trap controls, the secure IRQ/FIQ routing controls, the per-level system-register interface enables, the monitor-mode flag and two policy options. From these it picks exactly one outcome: perform the write, raise an undefined-instruction exception, trap to level 2, or trap to level 3 (the monitor).

The checks form a strictly ordered chain whose length and membership differ per level. Conditions that need level 2 or level 3 only count when those levels are present. The chosen outcome is a one-hot vector, returned with a syndrome class for traps. With the default parameter setting it is captured in an output register whenever a request strobe is seen. Taking the exception and carrying out the register write are left to the surrounding logic.

Top module: `swint_wr_perm`

## Requirements
- R1: A request with `cur_lvl` = 0 always yields undefined, whatever the other inputs are.
- R2: At level 1 the first check is the priority-undefined check: when level 3 is present, `route_irq` and `route_fiq` are both 1 and `undef_prio` is 1, the result is undefined, even if a level-2 trap control is also set.
- R3: At level 1 a set `hyp_cp_trap` (level 2 present) traps to level 2 ahead of the interface-enable check, and a clear `ifen_l1` gives undefined ahead of the remaining level-2 traps.
- R4: At level 1, `hyp_common_trap`, `hyp_fiq_virt` or `hyp_irq_virt` (level 2 present) traps to level 2, ahead of the level-3 routing check.
- R5: When no earlier check fires, IRQ and FIQ both routed to a present level 3 give undefined if `undef_sel` is 1 and a trap to level 3 otherwise. With only one of the two routed, the write is performed.
- R6: At level 1, when level 3 uses the 32-bit state (`l3_narrow` = 1) and `mon_mode` is 1, both the priority-undefined check and the routing check are skipped.
- R7: At level 2 the chain is: priority-undefined, then undefined if `ifen_l2` is 0, then the routing check (no monitor skip), then write. The hypervisor trap controls have no effect at level 2.
- R8: At level 3 the result is undefined when `ifen_l3` is 0 and write otherwise. Routing and hypervisor controls have no effect.
- R9: With `l2_on` = 0 the hypervisor trap controls have no effect. With `l3_on` = 0 the routing and priority options have no effect.
- R10: `out_code` is the trap class 0x03 for a trap to level 2 and for a trap to a 64-bit level 3. It is 0 for a trap to a 32-bit level 3, for write and for undefined.
- R11: `out_res` is one-hot: bit 0 write, bit 1 undefined, bit 2 trap to level 2, bit 3 trap to level 3. It is captured on the clock edge where `req_vld` is 1 and appears one cycle later with `out_vld` = 1. It holds while no request arrives. After reset `out_vld`, `out_res` and `out_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 1 | Request strobe; inputs are evaluated in this cycle |
| cur_lvl | input | 2 | Exception level of the access (0 to 3) |
| l2_on | input | 1 | Level 2 is implemented and enabled |
| l3_on | input | 1 | Level 3 is implemented |
| l3_narrow | input | 1 | Level 3 uses the 32-bit execution state |
| mon_mode | input | 1 | Processor is in monitor mode |
| undef_prio | input | 1 | Give undefined priority when IRQ/FIQ both go to level 3 |
| undef_sel | input | 1 | Routing check gives undefined instead of a trap |
| route_irq | input | 1 | IRQ routed to level 3 |
| route_fiq | input | 1 | FIQ routed to level 3 |
| hyp_cp_trap | input | 1 | Level-2 coprocessor-register trap control |
| hyp_common_trap | input | 1 | Level-2 common interface-register trap control |
| hyp_fiq_virt | input | 1 | Level-2 FIQ virtualization control |
| hyp_irq_virt | input | 1 | Level-2 IRQ virtualization control |
| ifen_l1 | input | 1 | Register interface enable seen at level 1 |
| ifen_l2 | input | 1 | Register interface enable seen at level 2 |
| ifen_l3 | input | 1 | Register interface enable seen at level 3 |
| out_vld | output | 1 | Outcome valid (one cycle after a request) |
| out_res | output | 4 | One-hot outcome |
| out_code | output | 6 | Trap syndrome class |

## Verification
The assertions assume that every input is stable and defined in the cycle `req_vld` is sampled. The routing and ordering properties also assume that `cur_lvl` names the level whose chain should run, even when `l2_on` or `l3_on` says that level is absent. The bench holds to this by setting all inputs on the falling edge, together with the strobe, and clearing the strobe on the next falling edge. Every case starts from a benign baseline at level 1, so that each scenario changes only the controls it targets.

// File: rtl/swp_pkg.sv
package swp_pkg;

  typedef enum logic [1:0] {
    DEC_WRITE = 2'd0,
    DEC_UNDEF = 2'd1,
    DEC_TRAP2 = 2'd2,
    DEC_TRAP3 = 2'd3
  } dec_e;

  localparam int N_DEC = 4;

  typedef struct packed {
    logic prio_l1;
    logic prio_l2;
    logic route_l1;
    logic route_l2;
    logic hyp_cp;
    logic hyp_tc;
    logic hyp_virt;
    logic l3_wide;
  } cond_t;

  function automatic logic [N_DEC-1:0] dec_to_vec(input dec_e d);
    return N_DEC'(1) << d;
  endfunction

  function automatic dec_e route_outcome(input logic sel_undef);
    return sel_undef ? DEC_UNDEF : DEC_TRAP3;
  endfunction

  function automatic logic carries_class(input dec_e d, input logic l3_wide);
    return (d == DEC_TRAP2) || ((d == DEC_TRAP3) && l3_wide);
  endfunction

endpackage

// File: rtl/swp_cond.sv
module swp_cond
  import swp_pkg::*;
(
  input  logic  l2_on,
  input  logic  l3_on,
  input  logic  l3_narrow,
  input  logic  mon_mode,
  input  logic  undef_prio,
  input  logic  route_irq,
  input  logic  route_fiq,
  input  logic  hyp_cp_trap,
  input  logic  hyp_common_trap,
  input  logic  hyp_fiq_virt,
  input  logic  hyp_irq_virt,
  output cond_t cond
);

  logic both_routed;
  logic mon_skip;

  assign both_routed = l3_on & route_irq & route_fiq;
  assign mon_skip    = l3_narrow & mon_mode;

  always_comb begin
    cond          = '0;
    cond.prio_l1  = both_routed & undef_prio & ~mon_skip;
    cond.prio_l2  = both_routed & undef_prio;
    cond.route_l1 = both_routed & ~mon_skip;
    cond.route_l2 = both_routed;
    cond.hyp_cp   = l2_on & hyp_cp_trap;
    cond.hyp_tc   = l2_on & hyp_common_trap;
    cond.hyp_virt = l2_on & (hyp_fiq_virt | hyp_irq_virt);
    cond.l3_wide  = ~l3_narrow;
  end

endmodule

// File: rtl/swp_chain.sv
module swp_chain
  import swp_pkg::*;
#(
  parameter int LVL_W = 2
) (
  input  logic [LVL_W-1:0] cur_lvl,
  input  cond_t            cond,
  input  logic             ifen_l1,
  input  logic             ifen_l2,
  input  logic             ifen_l3,
  input  logic             undef_sel,
  output dec_e             dec
);

  always_comb begin
    dec = DEC_UNDEF;
    case (cur_lvl)
      LVL_W'(1): begin
        if (cond.prio_l1)       dec = DEC_UNDEF;
        else if (cond.hyp_cp)   dec = DEC_TRAP2;
        else if (!ifen_l1)      dec = DEC_UNDEF;
        else if (cond.hyp_tc)   dec = DEC_TRAP2;
        else if (cond.hyp_virt) dec = DEC_TRAP2;
        else if (cond.route_l1) dec = route_outcome(undef_sel);
        else                    dec = DEC_WRITE;
      end
      LVL_W'(2): begin
        if (cond.prio_l2)       dec = DEC_UNDEF;
        else if (!ifen_l2)      dec = DEC_UNDEF;
        else if (cond.route_l2) dec = route_outcome(undef_sel);
        else                    dec = DEC_WRITE;
      end
      LVL_W'(3): dec = ifen_l3 ? DEC_WRITE : DEC_UNDEF;
      default:   dec = DEC_UNDEF;
    endcase
  end

endmodule

// File: rtl/swp_outreg.sv
module swp_outreg #(
  parameter bit REG_OUT = 1'b1,
  parameter int VEC_W   = 4,
  parameter int SYND_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [VEC_W-1:0]  in_vec,
  input  logic [SYND_W-1:0] in_code,
  output logic              out_vld,
  output logic [VEC_W-1:0]  out_vec,
  output logic [SYND_W-1:0] out_code
);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_vld  <= 1'b0;
          out_vec  <= '0;
          out_code <= '0;
        end else begin
          out_vld <= in_vld;
          if (in_vld) begin
            out_vec  <= in_vec;
            out_code <= in_code;
          end
        end
      end

      // R11: outcome is held between requests
      p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(out_vec) && $stable(out_code)));
    end else begin : g_comb
      assign out_vld  = in_vld;
      assign out_vec  = in_vld ? in_vec : '0;
      assign out_code = in_vld ? in_code : '0;
    end
  endgenerate

endmodule

// File: rtl/swint_wr_perm.sv
module swint_wr_perm
  import swp_pkg::*;
#(
  parameter bit              REG_OUT    = 1'b1,
  parameter int              LVL_W      = 2,
  parameter int              SYND_W     = 6,
  parameter logic [SYND_W-1:0] TRAP_CLASS = 6'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [LVL_W-1:0]  cur_lvl,
  input  logic              l2_on,
  input  logic              l3_on,
  input  logic              l3_narrow,
  input  logic              mon_mode,
  input  logic              undef_prio,
  input  logic              undef_sel,
  input  logic              route_irq,
  input  logic              route_fiq,
  input  logic              hyp_cp_trap,
  input  logic              hyp_common_trap,
  input  logic              hyp_fiq_virt,
  input  logic              hyp_irq_virt,
  input  logic              ifen_l1,
  input  logic              ifen_l2,
  input  logic              ifen_l3,
  output logic              out_vld,
  output logic [N_DEC-1:0]  out_res,
  output logic [SYND_W-1:0] out_code
);

  cond_t             cond;
  dec_e              dec;
  logic [N_DEC-1:0]  dec_vec;
  logic [SYND_W-1:0] dec_code;

  swp_cond u_cond (
    .l2_on           (l2_on),
    .l3_on           (l3_on),
    .l3_narrow       (l3_narrow),
    .mon_mode        (mon_mode),
    .undef_prio      (undef_prio),
    .route_irq       (route_irq),
    .route_fiq       (route_fiq),
    .hyp_cp_trap     (hyp_cp_trap),
    .hyp_common_trap (hyp_common_trap),
    .hyp_fiq_virt    (hyp_fiq_virt),
    .hyp_irq_virt    (hyp_irq_virt),
    .cond            (cond)
  );

  swp_chain #(.LVL_W(LVL_W)) u_chain (
    .cur_lvl   (cur_lvl),
    .cond      (cond),
    .ifen_l1   (ifen_l1),
    .ifen_l2   (ifen_l2),
    .ifen_l3   (ifen_l3),
    .undef_sel (undef_sel),
    .dec       (dec)
  );

  assign dec_vec  = dec_to_vec(dec);
  assign dec_code = carries_class(dec, cond.l3_wide) ? TRAP_CLASS : '0;

  swp_outreg #(.REG_OUT(REG_OUT), .VEC_W(N_DEC), .SYND_W(SYND_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (req_vld),
    .in_vec   (dec_vec),
    .in_code  (dec_code),
    .out_vld  (out_vld),
    .out_vec  (out_res),
    .out_code (out_code)
  );

  // R11: exactly one outcome per evaluated access
  p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ($countones(out_res) == 1));

  // R10: level-2 traps always carry the class code
  p_class_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_res == 4'b0100) |-> (out_code == TRAP_CLASS));

  // R10: write and undefined carry no code
  p_noclass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && (out_res[0] || out_res[1])) |-> (out_code == '0));

  generate
    if (REG_OUT) begin : g_chk
      // R1: user level always undefined
      p_user_undef_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && cur_lvl == LVL_W'(0)) |=> (out_vld && out_res == 4'b0010));

      // R8: level 3 with interface enabled always writes
      p_l3_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && cur_lvl == LVL_W'(3) && ifen_l3) |=> (out_res == 4'b0001));

      // R6: monitor-mode skip never lets a level-1 access reach level 3
      p_mon_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && cur_lvl == LVL_W'(1) && l3_narrow && mon_mode) |=> !out_res[3]);

      // R9: with level 3 absent no access traps to it
      p_no_l3_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !l3_on) |=> !out_res[3]);
    end
  endgenerate

endmodule

// File: tb/test_swint_wr_perm.sv
module test_swint_wr_perm;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_vld;
  logic [1:0] cur_lvl;
  logic       l2_on, l3_on, l3_narrow, mon_mode, undef_prio, undef_sel;
  logic       route_irq, route_fiq;
  logic       hyp_cp_trap, hyp_common_trap, hyp_fiq_virt, hyp_irq_virt;
  logic       ifen_l1, ifen_l2, ifen_l3;
  logic       out_vld;
  logic [3:0] out_res;
  logic [5:0] out_code;

  int n_run  = 0;
  int n_fail = 0;

  localparam logic [3:0] WR = 4'b0001;
  localparam logic [3:0] UD = 4'b0010;
  localparam logic [3:0] T2 = 4'b0100;
  localparam logic [3:0] T3 = 4'b1000;

  always #(CLK_PERIOD/2) clk = ~clk;

  swint_wr_perm i_swint_wr_perm (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_vld         (req_vld),
    .cur_lvl         (cur_lvl),
    .l2_on           (l2_on),
    .l3_on           (l3_on),
    .l3_narrow       (l3_narrow),
    .mon_mode        (mon_mode),
    .undef_prio      (undef_prio),
    .undef_sel       (undef_sel),
    .route_irq       (route_irq),
    .route_fiq       (route_fiq),
    .hyp_cp_trap     (hyp_cp_trap),
    .hyp_common_trap (hyp_common_trap),
    .hyp_fiq_virt    (hyp_fiq_virt),
    .hyp_irq_virt    (hyp_irq_virt),
    .ifen_l1         (ifen_l1),
    .ifen_l2         (ifen_l2),
    .ifen_l3         (ifen_l3),
    .out_vld         (out_vld),
    .out_res         (out_res),
    .out_code        (out_code)
  );

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic baseline();
    cur_lvl = 2'd1; l2_on = 1'b1; l3_on = 1'b1; l3_narrow = 1'b0; mon_mode = 1'b0;
    undef_prio = 1'b0; undef_sel = 1'b0; route_irq = 1'b0; route_fiq = 1'b0;
    hyp_cp_trap = 1'b0; hyp_common_trap = 1'b0; hyp_fiq_virt = 1'b0; hyp_irq_virt = 1'b0;
    ifen_l1 = 1'b1; ifen_l2 = 1'b1; ifen_l3 = 1'b1;
  endtask

  // inputs already set; strobe on a falling edge, check one cycle later
  task automatic fire(input string req, input logic [3:0] exp_res, input logic [5:0] exp_code);
    req_vld = 1'b1;
    @(negedge clk);
    req_vld = 1'b0;
    chk({req, " valid"}, {5'd0, out_vld}, 6'd1);
    chk({req, " outcome"}, {2'd0, out_res}, {2'd0, exp_res});
    chk({req, " code"}, out_code, exp_code);
    baseline();
  endtask

  task automatic t_reset();
    chk("R11 reset valid", {5'd0, out_vld}, 6'd0);
    chk("R11 reset outcome", {2'd0, out_res}, 6'd0);
    chk("R11 reset code", out_code, 6'd0);
  endtask

  task automatic t_user();
    baseline(); cur_lvl = 2'd0; fire("R1 user", UD, 6'h00);
    cur_lvl = 2'd0; hyp_cp_trap = 1'b1; route_irq = 1'b1; route_fiq = 1'b1;
    fire("R1 user with traps", UD, 6'h00);
  endtask

  task automatic t_l1_order();
    baseline(); route_irq = 1'b1; route_fiq = 1'b1; undef_prio = 1'b1; hyp_cp_trap = 1'b1;
    fire("R2 prio undef first", UD, 6'h00);
    hyp_cp_trap = 1'b1; ifen_l1 = 1'b0; fire("R3 cp trap before ifen", T2, 6'h03);
    ifen_l1 = 1'b0; hyp_common_trap = 1'b1; hyp_irq_virt = 1'b1;
    fire("R3 ifen before late traps", UD, 6'h00);
    hyp_common_trap = 1'b1; route_irq = 1'b1; route_fiq = 1'b1;
    fire("R4 common trap", T2, 6'h03);
    hyp_fiq_virt = 1'b1; route_irq = 1'b1; route_fiq = 1'b1; undef_sel = 1'b1;
    fire("R4 fiq virt before routing", T2, 6'h03);
    hyp_irq_virt = 1'b1; fire("R4 irq virt", T2, 6'h03);
    fire("R11 plain write", WR, 6'h00);
  endtask

  task automatic t_routing();
    baseline(); route_irq = 1'b1; route_fiq = 1'b1; undef_sel = 1'b1;
    fire("R5 routed undef select", UD, 6'h00);
    route_irq = 1'b1; route_fiq = 1'b1; fire("R5 routed trap", T3, 6'h03);
    route_irq = 1'b1; fire("R5 irq only", WR, 6'h00);
    route_fiq = 1'b1; fire("R5 fiq only", WR, 6'h00);
  endtask

  task automatic t_monitor();
    baseline(); l3_narrow = 1'b1; mon_mode = 1'b1; route_irq = 1'b1; route_fiq = 1'b1;
    undef_prio = 1'b1; fire("R6 monitor skip", WR, 6'h00);
    l3_narrow = 1'b1; route_irq = 1'b1; route_fiq = 1'b1;
    fire("R10 narrow monitor trap code", T3, 6'h00);
    mon_mode = 1'b1; route_irq = 1'b1; route_fiq = 1'b1;
    fire("R6 wide level 3 no skip", T3, 6'h03);
  endtask

  task automatic t_l2();
    baseline(); cur_lvl = 2'd2; hyp_cp_trap = 1'b1; hyp_common_trap = 1'b1;
    hyp_fiq_virt = 1'b1; hyp_irq_virt = 1'b1; ifen_l1 = 1'b0;
    fire("R7 hyp bits ignored", WR, 6'h00);
    cur_lvl = 2'd2; ifen_l2 = 1'b0; route_irq = 1'b1; route_fiq = 1'b1;
    fire("R7 ifen_l2 off", UD, 6'h00);
    cur_lvl = 2'd2; route_irq = 1'b1; route_fiq = 1'b1; fire("R7 routing", T3, 6'h03);
    cur_lvl = 2'd2; route_irq = 1'b1; route_fiq = 1'b1; undef_prio = 1'b1;
    l3_narrow = 1'b1; mon_mode = 1'b1; ifen_l2 = 1'b0;
    fire("R7 prio no monitor skip", UD, 6'h00);
  endtask

  task automatic t_l3();
    baseline(); cur_lvl = 2'd3; ifen_l3 = 1'b0; fire("R8 ifen_l3 off", UD, 6'h00);
    cur_lvl = 2'd3; route_irq = 1'b1; route_fiq = 1'b1; undef_prio = 1'b1;
    hyp_cp_trap = 1'b1; ifen_l1 = 1'b0; ifen_l2 = 1'b0;
    fire("R8 others ignored", WR, 6'h00);
  endtask

  task automatic t_presence();
    baseline(); l2_on = 1'b0; hyp_cp_trap = 1'b1; hyp_common_trap = 1'b1; hyp_irq_virt = 1'b1;
    fire("R9 no level 2", WR, 6'h00);
    l3_on = 1'b0; route_irq = 1'b1; route_fiq = 1'b1; undef_prio = 1'b1;
    fire("R9 no level 3", WR, 6'h00);
  endtask

  task automatic t_hold();
    baseline(); hyp_common_trap = 1'b1; fire("R11 before hold", T2, 6'h03);
    cur_lvl = 2'd0; ifen_l3 = 1'b0;
    @(negedge clk);
    chk("R11 idle valid", {5'd0, out_vld}, 6'd0);
    chk("R11 held outcome", {2'd0, out_res}, {2'd0, T2});
    chk("R11 held code", out_code, 6'h03);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_vld = 1'b0;
    baseline();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_user();
    t_l1_order();
    t_routing();
    t_monitor();
    t_l2();
    t_l3();
    t_presence();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule